// File: doc/BRIEF.md
# Serial Sector Receive Buffer

This block takes in one disk sector that arrives as a serial bit stream. Each sector starts with a 32-bit header. Next come the sector's data bits, and a 16-bit checksum ends it. The header fields are latched into output registers. The data bits are packed into bytes and written into an internal sector memory. The block computes a CRC over the data and compares it with the checksum that arrives after it.

The host reads the memory through a byte port. The port gives out data only when the sector has passed its checksum. Until then every read returns zero and flags an error. A completion interrupt rises when the checksum has been judged. The incoming bits come at whatever rate the drive sets, so the block accepts every strobed bit in the cycle it arrives. It has no way to stall the stream.

Top module: `sector_rx_buffer`

## Requirements
- R1: After reset, `data_valid_o`, `crc_err_o` and `irq_o` are low, the header outputs are zero, and a host read returns zero with `rd_err_o` high.
- R2: The first 32 strobed bits after a start hold, MSB first, the 16-bit cylinder, then the 8-bit sector number, then the 8-bit size code. All three appear on their outputs in the cycle after the 32nd bit.
- R3: The next SECTOR_BYTES×8 strobed bits (4096 by default) are packed MSB first into bytes. The bytes are stored at addresses 0 upward in arrival order.
- R4: The checksum is CRC-16 with polynomial 0x1021 and seed 0xFFFF. It is computed over the data bits only, shifting MSB first, with no reflection and no final XOR. The 16 bits that follow the data carry the checksum MSB first. On a match, `data_valid_o` goes high in the cycle after the last checksum bit and is low before that.
- R5: On a checksum mismatch, `crc_err_o` goes high and `data_valid_o` stays low. Reads then keep returning zero with `rd_err_o` high.
- R6: `irq_o` rises together with either result (valid or error). It stays high until the next start. Exactly one of `data_valid_o` and `crc_err_o` is high while `irq_o` is high.
- R7: A read strobed with `rd_en_i` returns its result one cycle later. If `data_valid_o` is high in the request cycle, the result is the stored byte with `rd_err_o` low. Otherwise it is zero with `rd_err_o` high. A read issued in the same cycle as the final checksum bit therefore gets the error result.
- R8: Every bit with `bit_vld_i` high is taken in its own cycle. This holds with back-to-back strobes, with idle gaps and with host reads at the same time. A bit without the strobe has no effect.
- R9: `sos_i` restarts reception even in the middle of a sector. The bit strobed in the same cycle counts as the first header bit. The valid, error and interrupt flags are low from the next cycle. Strobed bits that arrive after the checksum and before the next start are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sos_i | input | 1 | Start of sector; the bit strobed in this cycle is the first header bit |
| bit_i | input | 1 | Serial data bit |
| bit_vld_i | input | 1 | Bit strobe |
| rd_en_i | input | 1 | Host read request |
| rd_addr_i | input | ADDR_W (9) | Host byte address |
| rd_data_o | output | 8 | Read result, one cycle after the request |
| rd_err_o | output | 1 | Read refused because the sector is not valid |
| data_valid_o | output | 1 | Sector received with a matching checksum |
| crc_err_o | output | 1 | Sector received with a checksum mismatch |
| irq_o | output | 1 | Completion interrupt, held until the next start |
| cyl_o | output | CYL_W (16) | Captured cylinder number |
| sec_num_o | output | SEC_W (8) | Captured sector number |
| size_code_o | output | SIZE_W (8) | Captured size code |

## Verification
A host read and the checksum decision can fall in the same cycle. The bench raises `rd_en_i` in the cycle that carries the final checksum bit, and the scoreboard expects zero with the read-error bit set. It then issues a read in the next cycle and expects the stored byte. A second collision is between host reads and the incoming stream. The bench issues reads in the gap cycles of a gapped sector while bits keep arriving. Each read must come back refused, and the sector that follows must still assemble bit-exact.

// File: rtl/sector_rx_pkg.sv
package sector_rx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_DATA,
      ST_CRC,
      ST_DONE
   } rx_state_e;
endpackage

// File: rtl/sector_crc_calc.sv
module sector_crc_calc #(
   parameter int             W    = 16,
   parameter logic [W-1:0]   POLY = 16'h1021,
   parameter logic [W-1:0]   SEED = 16'hFFFF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         init_i,
   input  logic         en_i,
   input  logic         bit_i,
   output logic [W-1:0] crc_o
);
   logic [W-1:0] crc_q;
   logic [W-1:0] crc_nxt;
   logic         fb;

   assign fb = crc_q[W-1] ^ bit_i;

   for (genvar i = 0; i < W; i++) begin : g_tap
      if (i == 0) begin : g_lsb
         assign crc_nxt[i] = fb & POLY[i];
      end else begin : g_up
         assign crc_nxt[i] = crc_q[i-1] ^ (fb & POLY[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      crc_q <= SEED;
      else if (init_i) crc_q <= SEED;
      else if (en_i)   crc_q <= crc_nxt;
   end

   assign crc_o = crc_q;
endmodule

// File: rtl/sector_hdr_capture.sv
module sector_hdr_capture #(
   parameter int CYL_W  = 16,
   parameter int SEC_W  = 8,
   parameter int SIZE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              last_i,
   input  logic              bit_i,
   output logic [CYL_W-1:0]  cyl_o,
   output logic [SEC_W-1:0]  sec_o,
   output logic [SIZE_W-1:0] size_o
);
   localparam int HB = CYL_W + SEC_W + SIZE_W;

   logic [HB-2:0] sh_q;
   logic [HB-1:0] full;

   assign full = {sh_q, bit_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         cyl_o  <= '0;
         sec_o  <= '0;
         size_o <= '0;
      end else if (en_i) begin
         sh_q <= full[HB-2:0];
         if (last_i) begin
            cyl_o  <= full[HB-1 -: CYL_W];
            sec_o  <= full[SIZE_W +: SEC_W];
            size_o <= full[SIZE_W-1:0];
         end
      end
   end
endmodule

// File: rtl/sector_byte_packer.sv
module sector_byte_packer #(
   parameter int ADDR_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              en_i,
   input  logic              bit_i,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [7:0]        wr_data_o
);
   logic [6:0]        sh_q;
   logic [2:0]        idx_q;
   logic [ADDR_W-1:0] addr_q;

   assign wr_en_o   = en_i && (idx_q == 3'd7);
   assign wr_data_o = {sh_q, bit_i};
   assign wr_addr_o = addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         idx_q  <= '0;
         addr_q <= '0;
      end else if (clear_i) begin
         sh_q   <= '0;
         idx_q  <= '0;
         addr_q <= '0;
      end else if (en_i) begin
         sh_q  <= {sh_q[5:0], bit_i};
         idx_q <= idx_q + 3'd1;
         if (idx_q == 3'd7) addr_q <= addr_q + 1'b1;
      end
   end
endmodule

// File: rtl/sector_rd_port.sv
module sector_rd_port #(
   parameter int DEPTH  = 512,
   parameter int ADDR_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [7:0]        wr_data_i,
   input  logic              allow_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [7:0]        rd_data_o,
   output logic              rd_err_o
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data_o <= '0;
         rd_err_o  <= 1'b0;
      end else begin
         rd_data_o <= (rd_en_i && allow_i) ? mem[rd_addr_i] : '0;
         rd_err_o  <= rd_en_i && !allow_i;
      end
   end
endmodule

// File: rtl/sector_rx_buffer.sv
module sector_rx_buffer
   import sector_rx_pkg::*;
#(
   parameter int           SECTOR_BYTES = 512,
   parameter int           CYL_W        = 16,
   parameter int           SEC_W        = 8,
   parameter int           SIZE_W       = 8,
   parameter int           CRC_W        = 16,
   parameter logic [15:0]  CRC_POLY     = 16'h1021,
   parameter logic [15:0]  CRC_SEED     = 16'hFFFF,
   localparam int          ADDR_W       = $clog2(SECTOR_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sos_i,
   input  logic              bit_i,
   input  logic              bit_vld_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [7:0]        rd_data_o,
   output logic              rd_err_o,
   output logic              data_valid_o,
   output logic              crc_err_o,
   output logic              irq_o,
   output logic [CYL_W-1:0]  cyl_o,
   output logic [SEC_W-1:0]  sec_num_o,
   output logic [SIZE_W-1:0] size_code_o
);
   localparam int HDR_BITS  = CYL_W + SEC_W + SIZE_W;
   localparam int DATA_BITS = SECTOR_BYTES * 8;
   localparam int CNT_W     = $clog2(DATA_BITS) + 1;

   if (SECTOR_BYTES < 2 || (SECTOR_BYTES & (SECTOR_BYTES - 1)) != 0) begin : g_bad_depth
      $error("SECTOR_BYTES must be a power of two of at least 2");
   end
   if (CRC_W != 16) begin : g_bad_crc
      $error("CRC_W must be 16");
   end
   if (HDR_BITS < 2 || HDR_BITS >= DATA_BITS) begin : g_bad_hdr
      $error("header width out of range");
   end

   rx_state_e         state_q, cur_state, state_d;
   logic [CNT_W-1:0]  cnt_q, cur_cnt, cnt_d;
   logic              in_rx, take;
   logic              hdr_bit, data_bit, crc_bit;
   logic              last_hdr, last_data, last_crc;
   logic [CRC_W-1:0]  crc_calc, crc_rx_q;
   logic              crc_match;
   logic              valid_q, err_q, irq_q;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [7:0]        wr_data;

   assign cur_state = sos_i ? ST_HDR : state_q;
   assign cur_cnt   = sos_i ? '0 : cnt_q;
   assign in_rx     = (cur_state == ST_HDR) || (cur_state == ST_DATA) || (cur_state == ST_CRC);
   assign take      = bit_vld_i && in_rx;

   assign hdr_bit   = take && (cur_state == ST_HDR);
   assign data_bit  = take && (cur_state == ST_DATA);
   assign crc_bit   = take && (cur_state == ST_CRC);
   assign last_hdr  = hdr_bit  && (cur_cnt == CNT_W'(HDR_BITS - 1));
   assign last_data = data_bit && (cur_cnt == CNT_W'(DATA_BITS - 1));
   assign last_crc  = crc_bit  && (cur_cnt == CNT_W'(CRC_W - 1));

   always_comb begin
      state_d = cur_state;
      cnt_d   = cur_cnt;
      if (take) begin
         if (last_hdr) begin
            state_d = ST_DATA;
            cnt_d   = '0;
         end else if (last_data) begin
            state_d = ST_CRC;
            cnt_d   = '0;
         end else if (last_crc) begin
            state_d = ST_DONE;
            cnt_d   = '0;
         end else begin
            cnt_d = cur_cnt + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       crc_rx_q <= '0;
      else if (sos_i)   crc_rx_q <= '0;
      else if (crc_bit) crc_rx_q <= {crc_rx_q[CRC_W-2:0], bit_i};
   end

   assign crc_match = ({crc_rx_q[CRC_W-2:0], bit_i} == crc_calc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         err_q   <= 1'b0;
         irq_q   <= 1'b0;
      end else if (sos_i) begin
         valid_q <= 1'b0;
         err_q   <= 1'b0;
         irq_q   <= 1'b0;
      end else if (last_crc) begin
         valid_q <= crc_match;
         err_q   <= !crc_match;
         irq_q   <= 1'b1;
      end
   end

   assign data_valid_o = valid_q;
   assign crc_err_o    = err_q;
   assign irq_o        = irq_q;

   sector_hdr_capture #(
      .CYL_W (CYL_W),
      .SEC_W (SEC_W),
      .SIZE_W(SIZE_W)
   ) u_hdr (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (hdr_bit),
      .last_i(last_hdr),
      .bit_i (bit_i),
      .cyl_o (cyl_o),
      .sec_o (sec_num_o),
      .size_o(size_code_o)
   );

   sector_crc_calc #(
      .W   (CRC_W),
      .POLY(CRC_POLY),
      .SEED(CRC_SEED)
   ) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .init_i(sos_i),
      .en_i  (data_bit),
      .bit_i (bit_i),
      .crc_o (crc_calc)
   );

   sector_byte_packer #(
      .ADDR_W(ADDR_W)
   ) u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (sos_i),
      .en_i     (data_bit),
      .bit_i    (bit_i),
      .wr_en_o  (wr_en),
      .wr_addr_o(wr_addr),
      .wr_data_o(wr_data)
   );

   sector_rd_port #(
      .DEPTH (SECTOR_BYTES),
      .ADDR_W(ADDR_W)
   ) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en_i  (wr_en),
      .wr_addr_i(wr_addr),
      .wr_data_i(wr_data),
      .allow_i  (valid_q),
      .rd_en_i  (rd_en_i),
      .rd_addr_i(rd_addr_i),
      .rd_data_o(rd_data_o),
      .rd_err_o (rd_err_o)
   );
endmodule

// File: rtl/sector_rx_buffer_chk.sv
module sector_rx_buffer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sos_i,
   input logic       rd_en_i,
   input logic       data_valid_o,
   input logic       crc_err_o,
   input logic       irq_o,
   input logic       rd_err_o,
   input logic [7:0] rd_data_o
);
   // R7: a read issued while not valid comes back refused and zero
   p_read_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_i && !data_valid_o |=> rd_err_o && (rd_data_o == 8'h00));

   // R7: a read issued while valid is never refused
   p_read_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_i && data_valid_o |=> !rd_err_o);

   // R6: interrupt goes with exactly one result flag
   p_irq_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (data_valid_o ^ crc_err_o));

   // R6: a result flag never stands without the interrupt
   p_result_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (data_valid_o || crc_err_o) |-> irq_o);

   // R9: a start clears the flags in the next cycle
   p_sos_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sos_i |=> !data_valid_o && !crc_err_o && !irq_o);

   // R5: error flag and valid flag never coexist
   p_no_valid_on_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
      crc_err_o |-> !data_valid_o);
endmodule

bind sector_rx_buffer sector_rx_buffer_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sos_i       (sos_i),
   .rd_en_i     (rd_en_i),
   .data_valid_o(data_valid_o),
   .crc_err_o   (crc_err_o),
   .irq_o       (irq_o),
   .rd_err_o    (rd_err_o),
   .rd_data_o   (rd_data_o)
);

// File: tb/sector_rx_buffer_test.sv
module sector_rx_buffer_test;
   localparam int NBYTES = 512;
   localparam int NBITS  = 32 + NBYTES * 8 + 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sos_i = 1'b0;
   logic       bit_i = 1'b0;
   logic       bit_vld_i = 1'b0;
   logic       rd_en_i = 1'b0;
   logic [8:0] rd_addr_i = '0;
   logic [7:0] rd_data_o;
   logic       rd_err_o;
   logic       data_valid_o;
   logic       crc_err_o;
   logic       irq_o;
   logic [15:0] cyl_o;
   logic [7:0]  sec_num_o;
   logic [7:0]  size_code_o;

   int checks = 0;
   int errors = 0;

   logic [7:0] exp_mem [NBYTES];
   logic       cur_valid = 1'b0;
   logic [8:0] sb_q [$];
   logic       rd_seen = 1'b0;
   logic       stream [NBITS];

   always #10 clk = ~clk;

   sector_rx_buffer uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .sos_i       (sos_i),
      .bit_i       (bit_i),
      .bit_vld_i   (bit_vld_i),
      .rd_en_i     (rd_en_i),
      .rd_addr_i   (rd_addr_i),
      .rd_data_o   (rd_data_o),
      .rd_err_o    (rd_err_o),
      .data_valid_o(data_valid_o),
      .crc_err_o   (crc_err_o),
      .irq_o       (irq_o),
      .cyl_o       (cyl_o),
      .sec_num_o   (sec_num_o),
      .size_code_o (size_code_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // monitor: pops one expected read result per issued read
   always @(posedge clk) rd_seen <= rd_en_i && rst_n;

   always @(negedge clk) begin
      if (rd_seen) begin
         if (sb_q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R7: read result with empty scoreboard");
         end else begin
            logic [8:0] e;
            e = sb_q.pop_front();
            check("R7 read data", {24'h0, rd_data_o}, {24'h0, e[7:0]});
            check("R7 read error", {31'h0, rd_err_o}, {31'h0, e[8]});
         end
      end
   end

   // driver: one cycle of stimulus; pushes the expected read result
   task automatic drive(input logic s, input logic v, input logic b, input logic r,
                        input logic [8:0] a, input logic [7:0] ed, input logic ee);
      sos_i     = s;
      bit_vld_i = v;
      bit_i     = b;
      rd_en_i   = r;
      rd_addr_i = a;
      if (r) sb_q.push_back({ee, ed});
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b0, 1'b0, '0, '0, 1'b0);
   endtask

   task automatic host_read(input logic [8:0] a);
      drive(1'b0, 1'b0, 1'b0, 1'b1, a, cur_valid ? exp_mem[a] : 8'h00, !cur_valid);
   endtask

   function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
      logic fb;
      fb = c[15] ^ b;
      return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
   endfunction

   task automatic send_sector(input logic [15:0] cyl, input logic [7:0] sn, input logic [7:0] sz,
                              input logic [7:0] mul, input logic [7:0] add,
                              input bit gaps, input bit bad_crc, input bit rd_last, input int stop_at);
      logic [31:0] hdr;
      logic [15:0] c;
      logic [7:0]  by;
      int          n;
      hdr = {cyl, sn, sz};
      c   = 16'hFFFF;
      for (int i = 0; i < 32; i++) stream[i] = hdr[31-i];
      for (int j = 0; j < NBYTES; j++) begin
         by = 8'(j * mul + add);
         exp_mem[j] = by;
         for (int k = 0; k < 8; k++) begin
            stream[32 + j*8 + k] = by[7-k];
            c = crc_step(c, by[7-k]);
         end
      end
      if (bad_crc) c = c ^ 16'h0100;
      for (int i = 0; i < 16; i++) stream[32 + NBYTES*8 + i] = c[15-i];
      n = (stop_at == 0) ? NBITS : stop_at;
      cur_valid = 1'b0;
      for (int k = 0; k < n; k++) begin
         if (gaps && (k % 7 == 3)) begin
            // R8: unstrobed bit plus a refused read in the gap
            drive(1'b0, 1'b0, ~stream[k], 1'b1, 9'(k % NBYTES), 8'h00, 1'b1);
         end
         if (rd_last && k == n - 1)
            drive(1'b0, 1'b1, stream[k], 1'b1, 9'd0, 8'h00, 1'b1);
         else
            drive(k == 0, 1'b1, stream[k], 1'b0, '0, '0, 1'b0);
         if (k == 31) begin
            check("R2 cylinder", {16'h0, cyl_o}, {16'h0, cyl});
            check("R2 sector number", {24'h0, sec_num_o}, {24'h0, sn});
            check("R2 size code", {24'h0, size_code_o}, {24'h0, sz});
         end
         if (k == NBITS - 2) begin
            check("R4 not valid before last bit", {31'h0, data_valid_o}, 32'h0);
            check("R6 no irq before last bit", {31'h0, irq_o}, 32'h0);
         end
      end
      if (n == NBITS) begin
         cur_valid = !bad_crc;
         check(bad_crc ? "R5 valid stays low" : "R4 valid set", {31'h0, data_valid_o}, {31'h0, !bad_crc});
         check(bad_crc ? "R5 error flag" : "R4 no error", {31'h0, crc_err_o}, {31'h0, bad_crc});
         check("R6 irq raised", {31'h0, irq_o}, 32'h1);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1 valid", {31'h0, data_valid_o}, 32'h0);
      check("R1 crc error", {31'h0, crc_err_o}, 32'h0);
      check("R1 irq", {31'h0, irq_o}, 32'h0);
      check("R1 header", {cyl_o, sec_num_o, size_code_o}, 32'h0);
      host_read(9'd5);   // R1: refused read after reset
      idle(2);

      // R3 R4: clean back-to-back sector, data checked by reads
      send_sector(16'hA5C3, 8'h17, 8'h02, 8'd3, 8'd1, 1'b0, 1'b0, 1'b0, 0);
      host_read(9'd0);
      host_read(9'd1);
      host_read(9'd255);
      host_read(9'd511);
      idle(3);
      check("R6 irq held", {31'h0, irq_o}, 32'h1);

      // R9: strobes after completion are ignored
      for (int i = 0; i < 40; i++) drive(1'b0, 1'b1, i[0] ^ i[2], 1'b0, '0, '0, 1'b0);
      check("R9 valid kept after extra bits", {31'h0, data_valid_o}, 32'h1);
      host_read(9'd2);
      host_read(9'd300);
      idle(2);

      // R7: read in the cycle of the final checksum bit is refused, next cycle served
      send_sector(16'h0102, 8'h3C, 8'h02, 8'd7, 8'd200, 1'b0, 1'b0, 1'b1, 0);
      host_read(9'd0);
      host_read(9'd77);
      idle(2);

      // R5 R8: gapped sector with reads during reception, bad checksum
      send_sector(16'hFFFE, 8'hC8, 8'h01, 8'd11, 8'd9, 1'b1, 1'b1, 1'b0, 0);
      host_read(9'd0);
      host_read(9'd100);
      idle(2);
      check("R5 error held", {31'h0, crc_err_o}, 32'h1);

      // R9: bare start clears flags
      drive(1'b1, 1'b0, 1'b0, 1'b0, '0, '0, 1'b0);
      check("R9 error cleared", {31'h0, crc_err_o}, 32'h0);
      check("R9 irq cleared", {31'h0, irq_o}, 32'h0);
      idle(2);

      // R9: restart in the middle of the data phase, then a full gapped sector
      send_sector(16'h1111, 8'h22, 8'h02, 8'd5, 8'd5, 1'b0, 1'b0, 1'b0, 1000);
      send_sector(16'h7E81, 8'h05, 8'h03, 8'd13, 8'd77, 1'b1, 1'b0, 1'b0, 0);
      host_read(9'd0);
      host_read(9'd128);
      host_read(9'd510);
      host_read(9'd511);
      idle(4);

      check("R7 scoreboard drained", sb_q.size(), 32'h0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule